// File: doc/BRIEF.md
# Supply Monitor Reset Sequencer

This block turns a raw "supply is above its trip point" indication into the three control signals that guard a battery-backed memory and its host. It first brings the raw indication into the clock domain through two flops. A short glitch filter then removes brief dropouts. The filtered level drives a tick-based sequencer. When the supply is lost, the memory is write-protected and the host reset is pulled low straight away. When the supply returns, write protection is lifted after a short recovery count of ticks. The reset is released only after a longer hold count.

The reset output models an open-drain pin: the block only enables a pull-low driver and never drives high. A third output enables the backup battery. It is set on the first valid power-up after the block's reset and then stays set through any later supply loss. Durations are given in ticks of an external timebase, so a 1 ms tick gives the usual 100 ms / 200 ms windows with the default parameters. The glitch filter length is given in clock cycles.

Top module: `supply_seq_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `wp_o` = 1, `rst_pull_o` = 1 (pull-low enabled, reset active) and `batt_en_o` = 0. `rst_pull_o` is a drive-low enable only: 1 means pull low, 0 means release.
- R2: A supply loss (raw input low for at least FILT_LEN cycles) sets both `wp_o` and `rst_pull_o` to 1 on clock edge FILT_LEN+3, counting the first edge after the input falls as edge 1.
- R3: With `tick_i` held high, `wp_o` drops to 0 on edge FILT_LEN+WP_TICKS+3 after the raw input rises.
- R4: With `tick_i` held high, `rst_pull_o` drops to 0 on edge FILT_LEN+RST_TICKS+3 after the raw input rises. RST_TICKS must exceed WP_TICKS.
- R5: Only clock edges with `tick_i` high, taken while the filtered supply is good, advance the recovery windows. With no ticks, protection and reset are held indefinitely. With periodic ticks, a release comes one edge after the WP_TICKS-th (or RST_TICKS-th) counted tick.
- R6: A supply loss during recovery restarts both windows. `wp_o` and `rst_pull_o` go back to 1, and the next rise again needs the full R3/R4 delays.
- R7: A raw low pulse shorter than FILT_LEN cycles has no effect on any output. A pulse of exactly FILT_LEN cycles counts as a loss.
- R8: `batt_en_o` rises on edge FILT_LEN+3 after the first raw rise following reset. It then stays 1 through supply losses until the next `rst`.
- R9: Reset is never released while write protection is on: `rst_pull_o` = 0 implies `wp_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase tick, one clock wide per tick unit |
| supply_ok_i | input | 1 | Raw asynchronous supply-above-trip indication |
| wp_o | output | 1 | Write-protect to the memory, 1 = protected |
| rst_pull_o | output | 1 | Open-drain reset pull-low enable, 1 = reset asserted |
| batt_en_o | output | 1 | Sticky backup-battery enable |

## Verification
A wrong filter count or a lost synchronizer stage moves every edge-exact release and loss time by a whole number of cycles. Such a shift is visible within about a dozen clocks of any supply transition. A tick counter that restarts wrongly, or that saturates early, shows up as an early or late release in the periodic-tick and mid-recovery-drop runs. A battery flag that is not sticky shows up on the first supply loss after power-up. Glitch pulses one cycle shorter than the filter length check that the filter is not too eager. Pulses of exactly the filter length check that it is not too lax.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;
  // Sequencer phase, derived each cycle from filtered supply and timer state
  typedef enum logic [1:0] {
    PH_DOWN  = 2'd0,  // supply bad: protect and reset
    PH_GUARD = 2'd1,  // supply good, recovery window running
    PH_HOLD  = 2'd2,  // writes allowed, reset still held
    PH_UP    = 2'd3   // fully released
  } phase_e;
endpackage

// File: rtl/supply_sync_filter.sv
module supply_sync_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic good_o
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [FW-1:0] RUN_LIM = FW'(FILT_LEN - 1);

  logic s1_q, s2_q, good_q;
  logic [FW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      good_q <= 1'b0;
      run_q  <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == good_q) begin
        run_q <= '0;
      end else if (run_q == RUN_LIM) begin
        good_q <= s2_q;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign good_o = good_q;

  // R7: the filtered level only ever moves to what the synchronizer showed
  assert_flip_follows_sync_R7: assert property (@(posedge clk) disable iff (rst)
    (good_q != $past(good_q)) |-> ($past(s2_q) == good_q));

  // R7: a change needs the synchronized level to differ on the previous cycle
  assert_flip_needs_diff_R7: assert property (@(posedge clk) disable iff (rst)
    (good_q != $past(good_q)) |-> ($past(s2_q) != $past(good_q)));
endmodule

// File: rtl/supply_hold_timer.sv
module supply_hold_timer #(
  parameter int WP_TICKS  = 100,
  parameter int RST_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  output logic wp_done_o,
  output logic rst_done_o
);
  localparam int CW = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0] WP_LIM  = CW'(WP_TICKS);
  localparam logic [CW-1:0] RST_LIM = CW'(RST_TICKS);

  generate
    if (WP_TICKS < 1 || RST_TICKS <= WP_TICKS) begin : g_bad_cfg
      $error("supply_hold_timer: need 1 <= WP_TICKS < RST_TICKS");
    end
  endgenerate

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != RST_LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign wp_done_o  = (cnt_q >= WP_LIM);
  assign rst_done_o = (cnt_q >= RST_LIM);

  // R5: the count moves only on a tick, or clears
  assert_step_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |-> ($past(tick_i) || cnt_q == '0));

  // R5: saturation at the reset hold length
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= RST_LIM);

  // R6: supply loss restarts the windows
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/supply_seq_top.sv
module supply_seq_top
  import supply_seq_pkg::*;
#(
  parameter int FILT_LEN  = 3,
  parameter int WP_TICKS  = 100,
  parameter int RST_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic supply_ok_i,
  output logic wp_o,
  output logic rst_pull_o,
  output logic batt_en_o
);
  logic good;
  logic wp_done, rst_done;
  phase_e phase;
  logic wp_q, pull_q, batt_q;

  supply_sync_filter #(.FILT_LEN(FILT_LEN)) filt_i (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (supply_ok_i),
    .good_o (good)
  );

  supply_hold_timer #(.WP_TICKS(WP_TICKS), .RST_TICKS(RST_TICKS)) tmr_i (
    .clk        (clk),
    .rst        (rst),
    .run_i      (good),
    .tick_i     (tick_i),
    .wp_done_o  (wp_done),
    .rst_done_o (rst_done)
  );

  always_comb begin
    if (!good)          phase = PH_DOWN;
    else if (rst_done)  phase = PH_UP;
    else if (wp_done)   phase = PH_HOLD;
    else                phase = PH_GUARD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= 1'b1;
      pull_q <= 1'b1;
      batt_q <= 1'b0;
    end else begin
      wp_q   <= (phase == PH_DOWN) || (phase == PH_GUARD);
      pull_q <= (phase != PH_UP);
      if (good) batt_q <= 1'b1;
    end
  end

  assign wp_o       = wp_q;
  assign rst_pull_o = pull_q;
  assign batt_en_o  = batt_q;

  // R2: a bad filtered supply protects and resets on the next edge
  assert_loss_protects_R2: assert property (@(posedge clk) disable iff (rst)
    !good |=> (wp_q && pull_q));

  // R8: the battery flag never clears outside reset
  assert_batt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    batt_q |=> batt_q);

  // R9: reset release implies protection already lifted
  assert_order_R9: assert property (@(posedge clk) disable iff (rst)
    !pull_q |-> !wp_q);

  // R3: protection only lifts while the supply stays good
  assert_wp_release_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(wp_q) |-> $past(good));
endmodule

// File: tb/supply_seq_top_tb_top.sv
`timescale 1ns/1ps
module supply_seq_top_tb_top;
  localparam int F  = 3;
  localparam int WP = 3;
  localparam int RS = 6;
  localparam int TD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic raw = 1'b0;
  logic wp, pull, batt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  supply_seq_top #(.FILT_LEN(F), .WP_TICKS(WP), .RST_TICKS(RS)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .supply_ok_i(raw),
    .wp_o(wp), .rst_pull_o(pull), .batt_en_o(batt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // tick_mode: 0 = always high, 1 = every TD edges, 2 = never
  // Records the first edge (1-based) at which each output reads 0 / batt reads 1
  task automatic run_edges(input int n_max, input int tick_mode,
                           output int wp_at, output int rd_at, output int bt_at);
    wp_at = -1; rd_at = -1; bt_at = -1;
    tick = (tick_mode == 0);
    for (int n = 1; n <= n_max; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (wp_at < 0 && !wp)   wp_at = n;
      if (rd_at < 0 && !pull) rd_at = n;
      if (bt_at < 0 && batt)  bt_at = n;
      if (tick_mode == 0)      tick = 1'b1;
      else if (tick_mode == 1) tick = ((n % TD) == TD - 1);
      else                     tick = 1'b0;
    end
  endtask

  // edges after a raw fall until both outputs read 1
  task automatic run_loss(input int n_max, output int at);
    at = -1;
    for (int n = 1; n <= n_max; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (at < 0 && wp && pull) at = n;
    end
  endtask

  function automatic int nth_tick_edge(input int k);
    int m = F + 3;  // first edge at which the filtered supply is good
    int c = 0;
    while (1) begin
      if (m % TD == 0) begin
        c++;
        if (c == k) return m;
      end
      m++;
    end
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int wa, ra, ba, la;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 wp in reset", wp, 1);
    chk("R1 pull in reset", pull, 1);
    chk("R1 batt in reset", batt, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 wp after reset", wp, 1);
    chk("R1 pull after reset", pull, 1);
    chk("R1 batt after reset", batt, 0);

    // R3 R4 R8 R9: first power-up, ticks every cycle
    raw = 1'b1;
    run_edges(20, 0, wa, ra, ba);
    chk("R3 wp release edge", wa, F + WP + 3);
    chk("R4 reset release edge", ra, F + RS + 3);
    chk("R8 batt set edge", ba, F + 3);
    chk("R9 wp before reset", int'(wa < ra), 1);

    // R7: glitch of F-1 cycles ignored
    raw = 1'b0;
    repeat (F - 1) begin @(posedge clk); @(negedge clk); end
    raw = 1'b1;
    run_edges(12, 0, wa, ra, ba);
    chk("R7 short glitch wp", wp, 0);
    chk("R7 short glitch pull", pull, 0);
    chk("R7 short glitch wp at first edge", wa, 1);

    // R2 R7: low pulse of exactly F cycles is a loss
    raw = 1'b0;
    la = -1;
    for (int n = 1; n <= 14; n++) begin
      @(posedge clk); @(negedge clk);
      if (n == F) raw = 1'b1;
      if (la < 0 && wp && pull) la = n;
    end
    chk("R7 F-cycle pulse is loss", la, F + 3);
    chk("R2 loss timing (pulse)", la, F + 3);
    run_edges(20, 0, wa, ra, ba);
    chk("R8 batt stays after loss", batt, 1);

    // R2: plain loss timing
    raw = 1'b0;
    run_loss(12, la);
    chk("R2 loss sets wp and reset", la, F + 3);
    chk("R8 batt sticky in loss", batt, 1);

    // R5: no ticks -> held indefinitely
    raw = 1'b1;
    run_edges(60, 2, wa, ra, ba);
    chk("R5 no tick wp held", wp, 1);
    chk("R5 no tick reset held", pull, 1);

    // R5: periodic ticks
    raw = 1'b0;
    run_loss(12, la);
    raw = 1'b1;
    run_edges(60, 1, wa, ra, ba);
    chk("R5 periodic wp release", wa, nth_tick_edge(WP) + 1);
    chk("R5 periodic reset release", ra, nth_tick_edge(RS) + 1);

    // R6: drop after wp release, before reset release
    raw = 1'b0;
    run_loss(12, la);
    raw = 1'b1;
    run_edges(F + WP + 4, 0, wa, ra, ba);
    chk("R6 mid-window wp released", wp, 0);
    chk("R6 mid-window reset held", pull, 1);
    raw = 1'b0;
    run_loss(10, la);
    chk("R6 drop reprotects", la, F + 3);
    raw = 1'b1;
    run_edges(20, 0, wa, ra, ba);
    chk("R6 wp restart full", wa, F + WP + 3);
    chk("R6 reset restart full", ra, F + RS + 3);

    // R6: drop during the guard window itself
    raw = 1'b0;
    run_loss(12, la);
    raw = 1'b1;
    run_edges(F + 4, 0, wa, ra, ba);
    raw = 1'b0;
    run_loss(10, la);
    chk("R6 guard drop wp", wp, 1);
    raw = 1'b1;
    run_edges(20, 0, wa, ra, ba);
    chk("R6 guard restart wp", wa, F + WP + 3);

    // R1 R8: reset clears the flag, next power-up sets it again
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    raw = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 batt cleared by reset", batt, 0);
    chk("R1 wp by reset", wp, 1);
    rst = 1'b0;
    repeat (6) begin @(posedge clk); @(negedge clk); end
    chk("R8 batt stays clear without supply", batt, 0);
    raw = 1'b1;
    run_edges(20, 0, wa, ra, ba);
    chk("R8 batt set after re-reset", ba, F + 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule